// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block produces the T-state timing for a single machine cycle on a processor bus in which the low data byte shares its pins with the low address byte. A controller requests a cycle by pulsing `start` while the sequencer is idle. The request carries a cycle type, an address and write data. The sequencer then walks through T1, T2, any wait states, T3 and, for an opcode fetch only, T4. On the way it drives the address-latch strobe, the status pair, the I/O-or-memory select, the read and write strobes and the shared bus. At the end of T3 of a read-type cycle it captures the byte found on the shared bus.

Address-latch enable is high in T1 of every cycle. During T1 the low address byte is on the shared bus, so an external latch can hold it. During I/O cycles the 8-bit port number is copied onto the upper address byte, which gives 256 port addresses. Synchronous reset starts an opcode fetch from address 0000H at once, with no request needed. When the sequencer has no cycle in progress it reports status 00 (halt).

Top module: `muxbus_cycle_seq`

## Requirements
- R1: While `rst_n` is low, the outputs show T1 of an opcode fetch from address 0000H: `ale`=1, `status`=11, `io_m`=0, `ad_out`=00H, `a_hi`=00H. After release, that fetch runs through its T-states without any request.
- R2: `ale` is 1 exactly in T1 of every cycle type and 0 in all other states. In T1, `ad_oe`=1 and `ad_out` equals the latched address bits 7..0.
- R3: Cycle type codes are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge, 6 bus idle; code 7 behaves as code 6. `status` is 11 for codes 0 and 5, 10 for codes 1, 3 and 6, and 01 for codes 2 and 4. `status` is 00 while no cycle is in progress. `io_m` is 1 only for codes 3, 4 and 5.
- R4: With `ready` high, an opcode fetch takes four T-states and every other cycle takes three. `cyc_last` is 1 in the final T-state, and `idle` returns to 1 in the following clock.
- R5: `rd_n` is 0 from T2 through T3 for codes 0, 1, 3 and 5. `wr_n` is 0 over the same span for codes 2 and 4, with `ad_oe`=1 and `ad_out` equal to the latched write data. The two strobes are never 0 together, and `ad_oe` is 0 whenever `rd_n` is 0.
- R6: `a_hi` carries the latched address bits 7..0 for the whole of an I/O read or I/O write cycle, and the latched address bits 15..8 for all other cycle types. It is 00H while idle.
- R7: `ready` is sampled at the clock edge that ends T2 and at each edge that ends a wait state. A low sample inserts a wait state in which the strobes, `a_hi` and `ad_out` keep their T2 values.
- R8: A bus idle cycle asserts neither `rd_n` nor `wr_n` and drives the shared bus only in T1.
- R9: For codes 0, 1, 3 and 5, `ad_in` is captured at the edge that ends T3. It appears on `rdata`, with `rdata_valid`=1, for exactly the next clock. Other cycle types leave `rdata_valid` at 0.
- R10: `start` is ignored while a cycle is in progress. The type, address and data inputs are latched at the edge that accepts `start`, and later changes to them have no effect on the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a cycle; accepted only when idle |
| cyc_type | input | 3 | Cycle type code (see R3) |
| addr | input | ADDR_W | Cycle address |
| wdata | input | DATA_W | Write data for write cycles |
| ready | input | 1 | Low requests wait states |
| ad_in | input | DATA_W | Shared bus value seen by the sequencer |
| ale | output | 1 | Address-latch strobe |
| status | output | 2 | Cycle status pair |
| io_m | output | 1 | 1 for I/O space cycles |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| a_hi | output | ADDR_W-DATA_W | Upper address byte |
| ad_out | output | DATA_W | Shared bus drive value |
| ad_oe | output | 1 | Shared bus drive enable |
| rdata | output | DATA_W | Byte captured at the end of T3 |
| rdata_valid | output | 1 | One-clock pulse marking `rdata` |
| idle | output | 1 | No cycle in progress; `start` accepted |
| cyc_last | output | 1 | Final T-state of the cycle |

## Verification
The hardest situation to reach is a run of several wait states in a write cycle followed by a correct exit. In that case the data must stay on the bus, the write strobe must stay low, and T3 must begin only after the last low `ready`. The directed write task holds `ready` low through T2 and a chosen number of wait states, then raises it in the last one. It checks every pin in every state. It also scrambles the address and data inputs after the request is accepted, which shows that only the latched values reach the pins. The reset fetch is also checked while reset is still held, since T1 is visible before the first active edge.

// File: rtl/bcs_pkg.sv
// Shared types for the multiplexed bus cycle sequencer.
// Assumes a 3-bit cycle code as listed in the brief.
package bcs_pkg;
    typedef enum logic [2:0] {
        CY_FETCH = 3'd0,
        CY_MEMRD = 3'd1,
        CY_MEMWR = 3'd2,
        CY_IORD  = 3'd3,
        CY_IOWR  = 3'd4,
        CY_INTA  = 3'd5,
        CY_BIDLE = 3'd6,
        CY_RSVD  = 3'd7
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } tstate_e;

    localparam logic [1:0] STS_HALT  = 2'b00;
    localparam logic [1:0] STS_WRITE = 2'b01;
    localparam logic [1:0] STS_READ  = 2'b10;
    localparam logic [1:0] STS_FETCH = 2'b11;
endpackage

// File: rtl/bcs_tstate_fsm.sv
// T-state sequencer. Accepts a request only in idle, latches its type,
// address and data, and steps T1-T2-(TW)*-T3-(T4 for fetch only).
// Assumes ready is synchronous to clk. Reset loads a fetch from address 0.
module bcs_tstate_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cyc_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output tstate_e           st,
    output cyc_e              cmd_type,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);
    cyc_e req_type;

    // Map the reserved code onto a bus idle cycle.
    always_comb begin
        req_type = cyc_e'(cyc_type);
        if (req_type == CY_RSVD) req_type = CY_BIDLE;
    end

    // Advance the T-state and latch a new request from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_T1;
            cmd_type  <= CY_FETCH;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st        <= ST_T1;
                    cmd_type  <= req_type;
                    cmd_addr  <= addr;
                    cmd_wdata <= wdata;
                end
                ST_T1:   st <= ST_T2;
                ST_T2:   st <= ready ? ST_T3 : ST_TW;
                ST_TW:   st <= ready ? ST_T3 : ST_TW;
                ST_T3:   st <= (cmd_type == CY_FETCH) ? ST_T4 : ST_IDLE;
                ST_T4:   st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcs_pin_decode.sv
// Pin decode: turns the T-state and latched request into bus pins.
// Purely combinational; assumes the request fields stay stable for the cycle.
module bcs_pin_decode
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  tstate_e           st,
    input  cyc_e              cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              ale,
    output logic [1:0]        status,
    output logic              io_m,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              idle,
    output logic              cyc_last,
    output logic              sample_en
);
    logic rd_kind, wr_kind, io_kind, mirror, window, busy;

    // Classify the latched cycle type.
    always_comb begin
        rd_kind = (cmd_type == CY_FETCH) || (cmd_type == CY_MEMRD) ||
                  (cmd_type == CY_IORD)  || (cmd_type == CY_INTA);
        wr_kind = (cmd_type == CY_MEMWR) || (cmd_type == CY_IOWR);
        io_kind = (cmd_type == CY_IORD)  || (cmd_type == CY_IOWR) ||
                  (cmd_type == CY_INTA);
        mirror  = (cmd_type == CY_IORD)  || (cmd_type == CY_IOWR);
    end

    // Strobe window spans T2, wait states and T3.
    always_comb begin
        busy   = (st != ST_IDLE);
        window = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    end

    // Status pair by cycle type; halt code when idle.
    always_comb begin
        if (!busy) begin
            status = STS_HALT;
        end else begin
            case (cmd_type)
                CY_FETCH, CY_INTA: status = STS_FETCH;
                CY_MEMWR, CY_IOWR: status = STS_WRITE;
                default:           status = STS_READ;
            endcase
        end
    end

    // Control strobes and cycle markers.
    always_comb begin
        ale       = (st == ST_T1);
        io_m      = busy && io_kind;
        rd_n      = !(window && rd_kind);
        wr_n      = !(window && wr_kind);
        idle      = !busy;
        cyc_last  = (st == ST_T4) || ((st == ST_T3) && (cmd_type != CY_FETCH));
        sample_en = (st == ST_T3) && rd_kind;
    end

    // Address and shared bus drive.
    always_comb begin
        if (!busy)       a_hi = '0;
        else if (mirror) a_hi = HI_W'(cmd_addr[DATA_W-1:0]);
        else             a_hi = cmd_addr[ADDR_W-1:DATA_W];
        ad_oe  = ale || (window && wr_kind);
        if (ale)                    ad_out = cmd_addr[DATA_W-1:0];
        else if (window && wr_kind) ad_out = cmd_wdata;
        else                        ad_out = '0;
    end
endmodule

// File: rtl/bcs_read_capture.sv
// Read capture: registers the shared bus at the end of T3 of read cycles
// and flags it for one clock. Assumes sample_en is high for one clock.
module bcs_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    // Capture bus data and raise the one-clock valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= sample_en;
            if (sample_en) rdata <= ad_in;
        end
    end
endmodule

// File: rtl/muxbus_cycle_seq.sv
// Top of the multiplexed bus cycle sequencer: T-state machine, pin decode
// and read capture. Assumes the caller waits for idle before each start.
module muxbus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cyc_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic [1:0]        status,
    output logic              io_m,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              idle,
    output logic              cyc_last
);
    tstate_e           st;
    cyc_e              cmd_type;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              sample_en;

    bcs_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
        .addr(addr), .wdata(wdata), .ready(ready), .st(st),
        .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    bcs_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
        .st(st), .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .ale(ale), .status(status), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .idle(idle),
        .cyc_last(cyc_last), .sample_en(sample_en)
    );

    bcs_read_capture #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .ad_in(ad_in),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );
endmodule

// File: rtl/bcs_checker.sv
// Protocol checker for the sequencer pins, bound into the top module.
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic [1:0]        status,
    input logic              io_m,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ad_oe,
    input logic [HI_W-1:0]   a_hi,
    input logic [DATA_W-1:0] ad_out,
    input logic              ready,
    input tstate_e           st
);
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_ale_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    p_io_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && io_m && status != 2'b11) |-> (a_hi == HI_W'(ad_out)));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T2 || st == ST_TW) && !ready) |=>
        (st == ST_TW && $stable(rd_n) && $stable(wr_n) && $stable(ad_out) && $stable(a_hi)));

    p_halt_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (status == 2'b00 && rd_n && wr_n && !ad_oe));
endmodule

bind muxbus_cycle_seq bcs_checker #(.DATA_W(DATA_W), .HI_W(HI_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .status(status), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .a_hi(a_hi), .ad_out(ad_out),
    .ready(ready), .st(st)
);

// File: tb/muxbus_cycle_seq_tb_top.sv
`timescale 1ns/100ps
module muxbus_cycle_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cyc_type = 3'd0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic        ready = 1'b1;
    logic [7:0]  ad_in = 8'h0;
    logic        ale, io_m, rd_n, wr_n, ad_oe, rdata_valid, idle, cyc_last;
    logic [1:0]  status;
    logic [7:0]  a_hi, ad_out, rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    muxbus_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
        .addr(addr), .wdata(wdata), .ready(ready), .ad_in(ad_in),
        .ale(ale), .status(status), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .rdata(rdata),
        .rdata_valid(rdata_valid), .idle(idle), .cyc_last(cyc_last)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Phase: 1=T1 2=T2 3=wait 4=T3 5=T4. Expected pins from the requirements.
    task automatic check_phase(string req, int ph, int ty_in, logic [15:0] a, logic [7:0] wd);
        int ty = (ty_in == 7) ? 6 : ty_in;
        bit rdk = (ty == 0 || ty == 1 || ty == 3 || ty == 5);
        bit wrk = (ty == 2 || ty == 4);
        bit iok = (ty == 3 || ty == 4 || ty == 5);
        bit mir = (ty == 3 || ty == 4);
        bit win = (ph >= 2 && ph <= 4);
        logic [1:0] es = (ty == 0 || ty == 5) ? 2'b11 : (wrk ? 2'b01 : 2'b10);
        bit el = (ph == 5) || (ph == 4 && ty != 0);
        logic [7:0] eh = mir ? a[7:0] : a[15:8];
        logic [7:0] eo = (ph == 1) ? a[7:0] : ((win && wrk) ? wd : 8'h00);
        logic [23:0] exp = {ph == 1, es, iok, !(win && rdk), !(win && wrk),
                            (ph == 1) || (win && wrk), el, eh, eo};
        logic [23:0] act = {ale, status, io_m, rd_n, wr_n, ad_oe, cyc_last, a_hi, ad_out};
        check(req, $sformatf("pins in phase %0d type %0d", ph, ty_in), 32'(act), 32'(exp));
    endtask

    task automatic check_idle(string req);
        check(req, "idle pins {idle,status,rd_n,wr_n,ad_oe,ale}",
              {26'd0, idle, status, rd_n, wr_n, ad_oe},
              {26'd0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0});
        check(req, "ale idle", {31'd0, ale}, 32'd0);
    endtask

    // One full cycle: request, walk every T-state, check capture and return to idle.
    task automatic run_cycle(string req, int ty, logic [15:0] a, logic [7:0] wd,
                             int nwait, logic [7:0] rv, bit hold_start);
        bit rdk = (ty == 0 || ty == 1 || ty == 3 || ty == 5);
        @(negedge clk);
        check_idle("R3");
        start = 1'b1; cyc_type = 3'(ty); addr = a; wdata = wd; ready = 1'b1;
        @(negedge clk);
        start = hold_start;
        if (hold_start) cyc_type = 3'd2;
        addr = ~a; wdata = ~wd;                 // R10: later input changes ignored
        check_phase(req, 1, ty, a, wd);
        @(negedge clk);
        check_phase(req, 2, ty, a, wd);
        ready = (nwait == 0);
        for (int w = 0; w < nwait; w++) begin
            @(negedge clk);
            check_phase("R7", 3, ty, a, wd);
            ready = (w == nwait - 1);
        end
        @(negedge clk);
        check_phase(req, 4, ty, a, wd);
        start = 1'b0;
        ad_in = rv;
        @(negedge clk);
        if (ty == 0) begin
            check_phase("R4", 5, ty, a, wd);
            check("R9", "rdata_valid in T4", {31'd0, rdata_valid}, 32'd1);
            check("R9", "rdata in T4", {24'd0, rdata}, {24'd0, rv});
            @(negedge clk);
            check("R9", "rdata_valid after T4", {31'd0, rdata_valid}, 32'd0);
        end else begin
            check("R9", "rdata_valid after T3", {31'd0, rdata_valid}, {31'd0, rdk});
            if (rdk) check("R9", "rdata after T3", {24'd0, rdata}, {24'd0, rv});
        end
        check_idle("R4");
        ad_in = 8'h00;
    endtask

    task automatic t_reset_fetch();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_phase("R1", 1, 0, 16'h0000, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); check_phase("R1", 2, 0, 16'h0000, 8'h00);
        @(negedge clk); check_phase("R1", 4, 0, 16'h0000, 8'h00);
        ad_in = 8'h3C;
        @(negedge clk); check_phase("R1", 5, 0, 16'h0000, 8'h00);
        check("R9", "reset fetch rdata", {24'd0, rdata}, 32'h3C);
        @(negedge clk); check_idle("R1");
        ad_in = 8'h00;
    endtask

    task automatic t_fetch();     run_cycle("R4", 0, 16'hA55A, 8'h00, 0, 8'hC9, 1'b0); endtask
    task automatic t_memrd();     run_cycle("R2", 1, 16'h1234, 8'h00, 0, 8'h7E, 1'b0); endtask
    task automatic t_memwr_wait(); run_cycle("R7", 2, 16'hBEEF, 8'h96, 3, 8'h00, 1'b0); endtask
    task automatic t_iord();      run_cycle("R6", 3, 16'h00F3, 8'h00, 1, 8'h41, 1'b0); endtask
    task automatic t_iowr();      run_cycle("R6", 4, 16'h0081, 8'h5A, 0, 8'h00, 1'b0); endtask
    task automatic t_inta();      run_cycle("R3", 5, 16'h4400, 8'h00, 2, 8'hFF, 1'b0); endtask
    task automatic t_busidle();   run_cycle("R8", 6, 16'h2468, 8'hAA, 0, 8'h13, 1'b0); endtask
    task automatic t_rsvd_code(); run_cycle("R3", 7, 16'h9999, 8'h55, 0, 8'h13, 1'b0); endtask
    task automatic t_start_busy(); run_cycle("R10", 1, 16'h8001, 8'h00, 1, 8'h22, 1'b1); endtask
    task automatic t_fetch_wait(); run_cycle("R5", 0, 16'hFFFF, 8'h00, 2, 8'h08, 1'b0); endtask

    initial begin
        t_reset_fetch();
        t_fetch();
        t_memrd();
        t_memwr_wait();
        t_iord();
        t_iowr();
        t_inta();
        t_busidle();
        t_rsvd_code();
        t_start_busy();
        t_fetch_wait();
        @(negedge clk);
        check_idle("R10");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule